// File: doc/BRIEF.md
# Compressed-to-Wide Instruction Expander

The expander turns one 16-bit compressed instruction into the matching 32-bit instruction of the full-width set. A fetch stage supplies a 32-bit fetch word. An endianness select picks which halfword is the current instruction, and the other halfword is passed on unchanged so that the fetch stage can use it next. Two architecture flags gate the encodings that exist only on later revisions. The first flag, `arch_v5`, enables register branch-link-exchange, the breakpoint form and the lone second half of a long branch. The second flag, `arch_v6`, enables the sign and zero extend group.

The block rebuilds each wide encoding from a fixed base pattern. It moves the register and immediate fields of the compressed form into their wide positions. Where the wide set expresses a scale through its rotate field, the immediate is copied unshifted. A 2-bit status reports one of three results: the word is a usable translation, the instruction is a branch-type form that another unit must carry out, or the pattern is undefined. For the second and third results the word is a fixed filler value. With the default setting the outputs are registered, so they appear one clock after the inputs. The output stage has two named states. After reset it holds the reset value, and after that it holds the translation of the previous cycle's inputs.

Top module: `expd_top`

## Requirements
- R1: When `big_endian` is 1 the current instruction is `fetch_word[31:16]` and `other_half` carries `fetch_word[15:0]`. When it is 0 the two halves swap roles.
- R2: Bits [15:11] of the current halfword select the format. Values 0–2 are an immediate shift: base 0xE1B00000, bits [12:11] placed at [6:5], [10:6] at [11:7], [5:3] at [2:0] and [2:0] at [14:12]. Value 3 is an add or subtract of a register or a 3-bit immediate. Values 4–7 are move, compare, add and subtract with an 8-bit immediate.
- R3: Format 8 with bit 10 clear is a 16-way ALU group indexed by bits [9:6]. Each entry uses one of four operand layouts: plain, shift-by-register, negate or multiply.
- R4: Format 8 with bit 10 set is the high-register group. Bit 7 adds 8 to the destination and bit 6 adds 8 to the source. It provides ADD 0xE0800000, CMP 0xE1500000, MOV 0xE1A00000 and exchange 0xE12FFF10 with the register from [6:3]. Ops 0xE and 0xF give 0xE12FFF30 only when `arch_v5` is 1. Ops 0, 4 and 8 are undefined.
- R5: Loads and stores are translated as follows. The PC-relative load uses imm8<<2. The register-offset forms are selected by bit 9. The word and byte immediate forms scale imm5 by 4 when bit 12 is 0 and leave it unscaled when bit 12 is 1. The halfword form moves [8:6] to [3:1] and [10:9] to [9:8], with load 0xE1D000B0 and store 0xE1C000B0. The SP-relative forms use imm8<<2.
- R6: Address generation relative to PC uses base 0xE28F0F00 and relative to SP uses 0xE28D0F00, with imm8 copied unshifted. Stack adjust uses 0xE28DDF00, or 0xE24DDF00 when bit 7 is set, with the 7-bit offset copied unshifted.
- R7: Push is 0xE92D0000, with bit 14 added when bit 8 is set. Pop is 0xE8BD0000, with bit 15 added when bit 8 is set. Multiple store is 0xE8A00000 and multiple load is 0xE8B00000, with the base register at [18:16]. The 8-bit register list goes to [7:0] in all these forms.
- R8: Pattern 0xDFnn gives 0xEF0000nn. Pattern 0xBEnn gives 0xE1200070 with nn[7:4] at [11:8] and nn[3:0] at [3:0], but only when `arch_v5` is 1. Otherwise it is undefined.
- R9: Branch-type forms report status 01. These are conditional branches (0xD000–0xDDFF), unconditional branch (0xE000–0xE7FF), both long-branch halves (0xF000–0xFFFF), 0xE800–0xEFFF when `arch_v5` is 1 and bit 0 is 0, and 0xB200–0xB2FF when `arch_v6` is 1.
- R10: Every other pattern reports status 10. Whenever the status is not 00 the word is `FILL_WORD` (default 0x0BADF00D).
- R11: With `REG_OUT`=1 the outputs follow the inputs one clock later. While `rst_n` is 0 the word is `FILL_WORD`, the status is 10 and `other_half` is 0.
- R12: Every word reported with status 00 has 4'hE in bits [31:28].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_word | input | 32 | Two fetched halfwords |
| big_endian | input | 1 | 1: current instruction in the upper half |
| arch_v5 | input | 1 | Enables the revision-5 encodings |
| arch_v6 | input | 1 | Enables the extend group as branch-handled |
| xword | output | 32 | Expanded wide instruction or filler |
| xstatus | output | 2 | 00 decoded, 01 branch-type, 10 undefined |
| other_half | output | 16 | The halfword not being translated |

## Verification
Two functions act in the same cycle: translating the current halfword, and forwarding the other halfword. A swap of the endianness select affects both at once. The bench makes them collide by filling the unused half with a value derived from the current one but different from it. It then sweeps all 65536 patterns, once with the lower half current and all flags set, and once with the upper half current and all flags clear. On every clock it judges the word, the status and the forwarded half against a behavioural model. A routing slip would show up as a wrong translation and a wrong forwarded half in the same sample.

// File: rtl/expd_pkg.sv
package expd_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        XS_DECODED = 2'b00,
        XS_BRANCH  = 2'b01,
        XS_UNDEF   = 2'b10
    } xstat_e;

    typedef enum logic [1:0] {
        LAY_PLAIN,
        LAY_SHREG,
        LAY_NEG,
        LAY_MUL
    } alu_lay_e;

    typedef struct packed {
        logic [WORD_W-1:0] base;
        alu_lay_e          lay;
    } alu_ent_t;

    // register-register ALU group, 16 operations
    function automatic alu_ent_t alu_entry(input logic [3:0] op);
        alu_ent_t e;
        unique case (op)
            4'h0: e = '{32'hE0100000, LAY_PLAIN};
            4'h1: e = '{32'hE0300000, LAY_PLAIN};
            4'h2: e = '{32'hE1B00010, LAY_SHREG};
            4'h3: e = '{32'hE1B00030, LAY_SHREG};
            4'h4: e = '{32'hE1B00050, LAY_SHREG};
            4'h5: e = '{32'hE0B00000, LAY_PLAIN};
            4'h6: e = '{32'hE0D00000, LAY_PLAIN};
            4'h7: e = '{32'hE1B00070, LAY_SHREG};
            4'h8: e = '{32'hE1100000, LAY_PLAIN};
            4'h9: e = '{32'hE2700000, LAY_NEG};
            4'hA: e = '{32'hE1500000, LAY_PLAIN};
            4'hB: e = '{32'hE1700000, LAY_PLAIN};
            4'hC: e = '{32'hE1900000, LAY_PLAIN};
            4'hD: e = '{32'hE0100090, LAY_MUL};
            4'hE: e = '{32'hE1D00000, LAY_PLAIN};
            default: e = '{32'hE1F00000, LAY_PLAIN};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/expd_half_sel.sv
module expd_half_sel
    import expd_pkg::*;
(
    input  logic [WORD_W-1:0] fetch_word,
    input  logic              big_endian,
    output logic [HALF_W-1:0] cur_half,
    output logic [HALF_W-1:0] oth_half
);
    logic [HALF_W-1:0] hi_h;
    logic [HALF_W-1:0] lo_h;

    assign hi_h = fetch_word[WORD_W-1:HALF_W];
    assign lo_h = fetch_word[HALF_W-1:0];

    always_comb begin
        if (big_endian) begin
            cur_half = hi_h;
            oth_half = lo_h;
        end else begin
            cur_half = lo_h;
            oth_half = hi_h;
        end
    end
endmodule

// File: rtl/expd_dp_group.sv
module expd_dp_group
    import expd_pkg::*;
#(
    parameter logic [31:0] FILL_WORD = 32'h0BAD_F00D
) (
    input  logic [10:0]       h,
    input  logic              arch_v5,
    output logic [WORD_W-1:0] dp_word,
    output xstat_e            dp_stat
);
    alu_ent_t   ent;
    logic [3:0] hd;
    logic [3:0] hs;

    assign ent = alu_entry(h[9:6]);
    assign hd  = {h[7], h[2:0]};
    assign hs  = {h[6], h[5:3]};

    always_comb begin
        dp_word = FILL_WORD;
        dp_stat = XS_DECODED;
        if (!h[10]) begin
            unique case (ent.lay)
                LAY_PLAIN: dp_word = ent.base | (32'(h[2:0]) << 16)
                                   | (32'(h[2:0]) << 12) | 32'(h[5:3]);
                LAY_SHREG: dp_word = ent.base | (32'(h[2:0]) << 12)
                                   | 32'(h[2:0]) | (32'(h[5:3]) << 8);
                LAY_NEG:   dp_word = ent.base | (32'(h[2:0]) << 12)
                                   | (32'(h[5:3]) << 16);
                LAY_MUL:   dp_word = ent.base | (32'(h[2:0]) << 16)
                                   | (32'(h[2:0]) << 8) | 32'(h[5:3]);
            endcase
        end else begin
            unique case (h[9:6])
                4'h1, 4'h2, 4'h3:
                    dp_word = 32'hE0800000 | (32'(hd) << 16) | (32'(hd) << 12) | 32'(hs);
                4'h5, 4'h6, 4'h7:
                    dp_word = 32'hE1500000 | (32'(hd) << 16) | (32'(hd) << 12) | 32'(hs);
                4'h9, 4'hA, 4'hB:
                    dp_word = 32'hE1A00000 | (32'(hd) << 16) | (32'(hd) << 12) | 32'(hs);
                4'hC, 4'hD:
                    dp_word = 32'hE12FFF10 | 32'(h[6:3]);
                4'hE, 4'hF: begin
                    if (arch_v5) dp_word = 32'hE12FFF30 | 32'(h[6:3]);
                    else         dp_stat = XS_UNDEF;
                end
                default: dp_stat = XS_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/expd_core.sv
module expd_core
    import expd_pkg::*;
#(
    parameter logic [31:0] FILL_WORD = 32'h0BAD_F00D
) (
    input  logic [HALF_W-1:0] h,
    input  logic              arch_v5,
    input  logic              arch_v6,
    output logic [WORD_W-1:0] core_word,
    output xstat_e            core_stat
);
    logic [WORD_W-1:0] dp_word;
    xstat_e            dp_stat;
    logic [WORD_W-1:0] rd12, rb16, lo3;

    expd_dp_group #(.FILL_WORD(FILL_WORD)) u_dp (
        .h       (h[10:0]),
        .arch_v5 (arch_v5),
        .dp_word (dp_word),
        .dp_stat (dp_stat)
    );

    assign rd12 = 32'(h[2:0]) << 12;
    assign rb16 = 32'(h[5:3]) << 16;
    assign lo3  = 32'(h[8:6]);

    always_comb begin
        core_word = FILL_WORD;
        core_stat = XS_DECODED;
        case (h[15:11])
            5'd0, 5'd1, 5'd2:
                core_word = 32'hE1B00000 | (32'(h[12:11]) << 5) | (32'(h[10:6]) << 7)
                          | 32'(h[5:3]) | rd12;
            5'd3: begin
                unique case (h[10:9])
                    2'd0: core_word = 32'hE0900000;
                    2'd1: core_word = 32'hE0500000;
                    2'd2: core_word = 32'hE2900000;
                    2'd3: core_word = 32'hE2500000;
                endcase
                core_word = core_word | lo3 | rb16 | rd12;
            end
            5'd4, 5'd5, 5'd6, 5'd7: begin
                unique case (h[12:11])
                    2'd0: core_word = 32'hE3B00000;
                    2'd1: core_word = 32'hE3500000;
                    2'd2: core_word = 32'hE2900000;
                    2'd3: core_word = 32'hE2500000;
                endcase
                core_word = core_word | 32'(h[7:0]) | (32'(h[10:8]) << 16)
                          | (32'(h[10:8]) << 12);
            end
            5'd8: begin
                core_word = dp_word;
                core_stat = dp_stat;
            end
            5'd9:
                core_word = 32'hE59F0000 | (32'(h[10:8]) << 12) | (32'(h[7:0]) << 2);
            5'd10, 5'd11: begin
                unique case ({h[9], h[11:10]})
                    3'b000: core_word = 32'hE7800000;
                    3'b001: core_word = 32'hE7C00000;
                    3'b010: core_word = 32'hE7900000;
                    3'b011: core_word = 32'hE7D00000;
                    3'b100: core_word = 32'hE18000B0;
                    3'b101: core_word = 32'hE19000D0;
                    3'b110: core_word = 32'hE19000B0;
                    3'b111: core_word = 32'hE19000F0;
                endcase
                core_word = core_word | rd12 | rb16 | lo3;
            end
            5'd12, 5'd13, 5'd14, 5'd15: begin
                unique case (h[12:11])
                    2'd0: core_word = 32'hE5800000;
                    2'd1: core_word = 32'hE5900000;
                    2'd2: core_word = 32'hE5C00000;
                    2'd3: core_word = 32'hE5D00000;
                endcase
                if (h[12]) core_word = core_word | rd12 | rb16 | 32'(h[10:6]);
                else       core_word = core_word | rd12 | rb16 | (32'(h[10:6]) << 2);
            end
            5'd16, 5'd17:
                core_word = (h[11] ? 32'hE1D000B0 : 32'hE1C000B0) | rd12 | rb16
                          | (32'(h[8:6]) << 1) | (32'(h[10:9]) << 8);
            5'd18, 5'd19:
                core_word = (h[11] ? 32'hE59D0000 : 32'hE58D0000)
                          | (32'(h[10:8]) << 12) | (32'(h[7:0]) << 2);
            5'd20, 5'd21:
                core_word = (h[11] ? 32'hE28D0F00 : 32'hE28F0F00)
                          | (32'(h[10:8]) << 12) | 32'(h[7:0]);
            5'd22, 5'd23: begin
                case (h[11:8])
                    4'h0: core_word = (h[7] ? 32'hE24DDF00 : 32'hE28DDF00) | 32'(h[6:0]);
                    4'h4: core_word = 32'hE92D0000 | 32'(h[7:0]);
                    4'h5: core_word = 32'hE92D4000 | 32'(h[7:0]);
                    4'hC: core_word = 32'hE8BD0000 | 32'(h[7:0]);
                    4'hD: core_word = 32'hE8BD8000 | 32'(h[7:0]);
                    4'hE: begin
                        if (arch_v5)
                            core_word = 32'hE1200070 | (32'(h[7:4]) << 8) | 32'(h[3:0]);
                        else
                            core_stat = XS_UNDEF;
                    end
                    4'h2: core_stat = arch_v6 ? XS_BRANCH : XS_UNDEF;
                    default: core_stat = XS_UNDEF;
                endcase
            end
            5'd24, 5'd25:
                core_word = (h[11] ? 32'hE8B00000 : 32'hE8A00000)
                          | (32'(h[10:8]) << 16) | 32'(h[7:0]);
            5'd26, 5'd27: begin
                if (h[11:8] == 4'hF)      core_word = 32'hEF000000 | 32'(h[7:0]);
                else if (h[11:8] == 4'hE) core_stat = XS_UNDEF;
                else                      core_stat = XS_BRANCH;
            end
            5'd29:
                core_stat = (arch_v5 && !h[0]) ? XS_BRANCH : XS_UNDEF;
            default:
                core_stat = XS_BRANCH;
        endcase
        if (core_stat != XS_DECODED) core_word = FILL_WORD;
    end
endmodule

// File: rtl/expd_top.sv
module expd_top
    import expd_pkg::*;
#(
    parameter logic [31:0] FILL_WORD = 32'h0BAD_F00D,
    parameter bit          REG_OUT   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] fetch_word,
    input  logic        big_endian,
    input  logic        arch_v5,
    input  logic        arch_v6,
    output logic [31:0] xword,
    output logic [1:0]  xstatus,
    output logic [15:0] other_half
);
    logic [HALF_W-1:0] cur_half;
    logic [HALF_W-1:0] oth_half;
    logic [WORD_W-1:0] core_word;
    xstat_e            core_stat;

    expd_half_sel u_sel (
        .fetch_word (fetch_word),
        .big_endian (big_endian),
        .cur_half   (cur_half),
        .oth_half   (oth_half)
    );

    expd_core #(.FILL_WORD(FILL_WORD)) u_core (
        .h         (cur_half),
        .arch_v5   (arch_v5),
        .arch_v6   (arch_v6),
        .core_word (core_word),
        .core_stat (core_stat)
    );

    generate
        if (REG_OUT) begin : g_reg
            // output stage: reset value, then previous cycle's translation
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    xword      <= FILL_WORD;
                    xstatus    <= XS_UNDEF;
                    other_half <= '0;
                end else begin
                    xword      <= core_word;
                    xstatus    <= core_stat;
                    other_half <= oth_half;
                end
            end

            // R11
            reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (xstatus == $past(core_stat)) && (other_half == $past(oth_half)));
        end else begin : g_comb
            assign xword      = core_word;
            assign xstatus    = core_stat;
            assign other_half = oth_half;
        end
    endgenerate

    // R10
    nondecoded_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xstatus != 2'b00) |-> (xword == FILL_WORD));

    // R12
    decoded_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_stat == XS_DECODED) |-> (core_word[31:28] == 4'hE));

    // R9
    uncond_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_half[15:11] == 5'b11100) || (cur_half[15:12] == 4'hF)) |-> (core_stat == XS_BRANCH));

    // R8
    bkpt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arch_v5 && (cur_half[15:8] == 8'hBE)) |-> (core_stat == XS_UNDEF));

    // R8
    swi_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_half[15:8] == 8'hDF) |-> ((core_stat == XS_DECODED)
                                       && (core_word == {24'hEF0000, cur_half[7:0]})));

    // R1
    endian_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        big_endian |-> ({cur_half, oth_half} == fetch_word));
endmodule

// File: tb/sim_expd_top.sv
module sim_expd_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] FILL = 32'h0BAD_F00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_word = '0;
    logic        big_endian = 1'b0;
    logic        arch_v5 = 1'b0;
    logic        arch_v6 = 1'b0;
    logic [31:0] xword;
    logic [1:0]  xstatus;
    logic [15:0] other_half;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    expd_top #(.FILL_WORD(FILL), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .big_endian(big_endian),
        .arch_v5(arch_v5), .arch_v6(arch_v6),
        .xword(xword), .xstatus(xstatus), .other_half(other_half)
    );

    function automatic int unsigned pick4(int unsigned k, int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
        if (k == 0) return a;
        if (k == 1) return b;
        if (k == 2) return c;
        return d;
    endfunction

    // behavioural model; status 0 decoded, 1 branch-type, 2 undefined
    function automatic void model(input int unsigned t, input bit v5, input bit v6,
                                  output int unsigned w, output int st, output string tag);
        int unsigned f  = (t >> 11) & 31;
        int unsigned rd = t & 7;
        int unsigned rs = (t >> 3) & 7;
        int unsigned rn = (t >> 6) & 7;
        int unsigned r8 = (t >> 8) & 7;
        int unsigned i8 = t & 255;
        int unsigned mid = (t >> 8) & 15;
        w = 0; st = 0; tag = "R2";
        if (f <= 2) begin
            w = 'hE1B00000 | (f << 5) | (((t >> 6) & 31) << 7) | rs | (rd << 12);
        end else if (f == 3) begin
            w = pick4((t >> 9) & 3, 'hE0900000, 'hE0500000, 'hE2900000, 'hE2500000)
              | rn | (rs << 16) | (rd << 12);
        end else if (f <= 7) begin
            w = pick4(f - 4, 'hE3B00000, 'hE3500000, 'hE2900000, 'hE2500000)
              | i8 | (r8 << 16) | (r8 << 12);
        end else if (f == 8 && (t & 'h400) == 0) begin
            int unsigned op = (t >> 6) & 15;
            int unsigned b;
            int lay;
            tag = "R3";
            case (op)
                0: begin b = 'hE0100000; lay = 0; end
                1: begin b = 'hE0300000; lay = 0; end
                2: begin b = 'hE1B00010; lay = 1; end
                3: begin b = 'hE1B00030; lay = 1; end
                4: begin b = 'hE1B00050; lay = 1; end
                5: begin b = 'hE0B00000; lay = 0; end
                6: begin b = 'hE0D00000; lay = 0; end
                7: begin b = 'hE1B00070; lay = 1; end
                8: begin b = 'hE1100000; lay = 0; end
                9: begin b = 'hE2700000; lay = 2; end
                10: begin b = 'hE1500000; lay = 0; end
                11: begin b = 'hE1700000; lay = 0; end
                12: begin b = 'hE1900000; lay = 0; end
                13: begin b = 'hE0100090; lay = 3; end
                14: begin b = 'hE1D00000; lay = 0; end
                default: begin b = 'hE1F00000; lay = 0; end
            endcase
            if (lay == 0)      w = b | (rd << 16) | (rd << 12) | rs;
            else if (lay == 1) w = b | (rd << 12) | rd | (rs << 8);
            else if (lay == 2) w = b | (rd << 12) | (rs << 16);
            else               w = b | (rd << 16) | (rd << 8) | rs;
        end else if (f == 8) begin
            int unsigned op = (t >> 6) & 15;
            int unsigned d = rd | ((t >> 4) & 8);
            int unsigned s = rs | ((t >> 3) & 8);
            int unsigned rx = (t >> 3) & 15;
            tag = "R4";
            if (op >= 1 && op <= 3)       w = 'hE0800000 | (d << 16) | (d << 12) | s;
            else if (op >= 5 && op <= 7)  w = 'hE1500000 | (d << 16) | (d << 12) | s;
            else if (op >= 9 && op <= 11) w = 'hE1A00000 | (d << 16) | (d << 12) | s;
            else if (op == 12 || op == 13) w = 'hE12FFF10 | rx;
            else if (op >= 14 && v5)      w = 'hE12FFF30 | rx;
            else st = 2;
        end else if (f == 9) begin
            tag = "R5"; w = 'hE59F0000 | (r8 << 12) | (i8 << 2);
        end else if (f == 10 || f == 11) begin
            int unsigned k = (t >> 10) & 3;
            tag = "R5";
            if ((t & 'h200) == 0) w = pick4(k, 'hE7800000, 'hE7C00000, 'hE7900000, 'hE7D00000);
            else                  w = pick4(k, 'hE18000B0, 'hE19000D0, 'hE19000B0, 'hE19000F0);
            w = w | (rd << 12) | (rs << 16) | rn;
        end else if (f >= 12 && f <= 15) begin
            int unsigned off = (t >> 6) & 31;
            tag = "R5";
            w = pick4(f - 12, 'hE5800000, 'hE5900000, 'hE5C00000, 'hE5D00000) | (rd << 12) | (rs << 16);
            if ((t & 'h1000) != 0) w = w | off;
            else                   w = w | (off << 2);
        end else if (f == 16 || f == 17) begin
            tag = "R5";
            w = ((f == 17) ? 'hE1D000B0 : 'hE1C000B0) | (rd << 12) | (rs << 16)
              | (rn << 1) | (((t >> 9) & 3) << 8);
        end else if (f == 18 || f == 19) begin
            tag = "R5";
            w = ((f == 19) ? 'hE59D0000 : 'hE58D0000) | (r8 << 12) | (i8 << 2);
        end else if (f == 20 || f == 21) begin
            tag = "R6";
            w = ((f == 21) ? 'hE28D0F00 : 'hE28F0F00) | (r8 << 12) | i8;
        end else if (f == 22 || f == 23) begin
            if (mid == 0) begin
                tag = "R6"; w = (((t & 'h80) != 0) ? 'hE24DDF00 : 'hE28DDF00) | (t & 127);
            end else if (mid == 4 || mid == 5) begin
                tag = "R7"; w = 'hE92D0000 | ((mid == 5) ? 'h4000 : 0) | i8;
            end else if (mid == 12 || mid == 13) begin
                tag = "R7"; w = 'hE8BD0000 | ((mid == 13) ? 'h8000 : 0) | i8;
            end else if (mid == 14 && v5) begin
                tag = "R8"; w = 'hE1200070 | ((i8 >> 4) << 8) | (i8 & 15);
            end else if (mid == 2 && v6) begin
                tag = "R9"; st = 1;
            end else begin
                tag = "R10"; st = 2;
            end
        end else if (f == 24 || f == 25) begin
            tag = "R7"; w = ((f == 25) ? 'hE8B00000 : 'hE8A00000) | (r8 << 16) | i8;
        end else if (f == 26 || f == 27) begin
            if (mid == 15)      begin tag = "R8"; w = 'hEF000000 | i8; end
            else if (mid == 14) begin tag = "R10"; st = 2; end
            else                begin tag = "R9"; st = 1; end
        end else if (f == 29) begin
            tag = "R9";
            st = (v5 && (t & 1) == 0) ? 1 : 2;
        end else begin
            tag = "R9"; st = 1;
        end
        if (st != 0) w = FILL;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    // drive one fetch word, sample one clock later away from the edge
    task automatic apply(input logic [15:0] cur, input logic [15:0] oth,
                         input bit be, input bit v5, input bit v6);
        int unsigned w;
        int st;
        string tag;
        @(negedge clk);
        big_endian = be; arch_v5 = v5; arch_v6 = v6;
        fetch_word = be ? {cur, oth} : {oth, cur};
        model(32'(cur), v5, v6, w, st, tag);
        @(posedge clk);
        #1;
        chk({tag, " word"}, xword, w);
        chk({tag, " status"}, 32'(xstatus), 32'(st));
        chk("R1 other", 32'(other_half), 32'(oth));
        if (st == 0) chk("R12 cond", 32'(xword[31:28]), 32'hE);
        if (st != 0) chk("R10 fill", xword, FILL);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset word", xword, FILL);
        chk("R11 reset status", 32'(xstatus), 32'd2);
        chk("R11 reset other", 32'(other_half), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corner cases
        apply(16'hBE12, 16'h1111, 1'b0, 1'b1, 1'b0);  // R8 breakpoint allowed
        apply(16'hBE12, 16'h2222, 1'b0, 1'b0, 1'b0);  // R8 breakpoint gated off
        apply(16'h47F0, 16'h3333, 1'b1, 1'b1, 1'b0);  // R4 exchange-link with v5
        apply(16'h47F0, 16'h4444, 1'b1, 1'b0, 1'b1);  // R4 undefined without v5
        apply(16'hB2C5, 16'h5555, 1'b0, 1'b0, 1'b1);  // R9 extend group with v6
        apply(16'hB2C5, 16'h6666, 1'b0, 1'b1, 1'b0);  // R10 extend group without v6
        apply(16'hE800, 16'h7777, 1'b1, 1'b1, 1'b0);  // R9 lone second half
        apply(16'hE801, 16'h8888, 1'b1, 1'b1, 1'b0);  // R10 odd lone second half
        apply(16'hDF7E, 16'h9999, 1'b0, 1'b0, 1'b0);  // R8 software interrupt
        apply(16'h1C00, 16'hAAAA, 1'b1, 1'b0, 1'b0);  // R2 add immediate

        // R11 reset during operation
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R11 mid reset word", xword, FILL);
        chk("R11 mid reset status", 32'(xstatus), 32'd2);
        chk("R11 mid reset other", 32'(other_half), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // full sweeps: R1..R10 across every pattern
        for (int i = 0; i < 65536; i++)
            apply(16'(i), 16'(i) ^ 16'h5A5A, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 65536; i++)
            apply(16'(i), 16'(i) ^ 16'hA5A5, 1'b1, 1'b0, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule